// File: doc/BRIEF.md
# Hardware Spinlock Register Bank

This block holds a bank of hardware semaphores that several processors use to share resources without a coherent atomic instruction. Each semaphore occupies one 32-bit word. A read of that word is an atomic test-and-set. It returns 0 when the semaphore was free, and in the same access it marks the semaphore as owned by the reader. It returns 1 when the semaphore was already held. Writing zero to the word frees the semaphore. A read-only identification word at offset 0x000 reports the bank size in a code field at bits 31:28, where code n means 2^(4+n) semaphores.

Every bus master has its own port. Each port has a read strobe, a write strobe, a byte address and write data. No port ever sees back-pressure: a strobe is accepted in the cycle it is high, and the port's response-ready pulses for exactly one cycle on the following edge, carrying the read data. The port does not wait for that pulse before issuing its next access. When several ports strike the bank in the same cycle, their accesses take effect one after another in port order, with port 0 first. This fixed priority settles every race over a semaphore. The semaphore count parameter must be 32, 64, 128 or 256. Any other value stops elaboration with an error.

Top module: `hw_spinlock_bank`

## Requirements
- R1: After reset every semaphore is free and no port shows response-ready. A reset in the middle of a run frees semaphores that were held.
- R2: A read of the identification word (byte offset 0x000) returns the count code (log2(NUM_LOCKS) minus 4) in bits 31:28 with all other bits 0. For 32 semaphores the value is 0x10000000.
- R3: Semaphore i sits at byte offset 0x100 + 4*i. A read of a free semaphore returns 0 and leaves the semaphore held.
- R4: A read of a held semaphore returns 1 and leaves it held.
- R5: Writing 0 to a semaphore frees it, so the next read of it returns 0.
- R6: A write of any nonzero value to a semaphore, and any write to the identification word, changes nothing.
- R7: A read of an offset that maps to nothing returns 0 and has no side effect on any semaphore. This covers an index at or beyond NUM_LOCKS, any non-word-aligned offset, and any other gap in the map.
- R8: Every access, read or write, raises that port's response-ready for exactly one cycle on the next clock edge. Write responses carry data 0.
- R9: When several ports read the same free semaphore in one cycle, only the lowest-numbered port gets 0 and every other port gets 1.
- R10: Accesses in one cycle apply in port order. A release on port 0 followed by a read of the same semaphore on port 1 gives port 1 the value 0. A port that raises both strobes together performs only the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rd | input | NUM_PORTS | Read strobe, one bit per port |
| req_wr | input | NUM_PORTS | Write strobe, one bit per port |
| req_addr | input | NUM_PORTS x ADDR_W | Byte address per port |
| req_wdata | input | NUM_PORTS x 32 | Write data per port |
| rsp_ready | output | NUM_PORTS | One-cycle response pulse per port |
| rsp_rdata | output | NUM_PORTS x 32 | Read data per port, valid with rsp_ready |

## Verification
The hardest case to reach from the ports is a same-cycle collision. Two masters must hit one semaphore in the same cycle, and its result depends on the order in which the two accesses take effect. The bench drives both ports together on one clock edge with the same free semaphore, and also pairs a release on port 0 with a read on port 1. Side effects that must not happen (out-of-range aliasing, nonzero writes) cannot be seen directly. The bench exposes them by reading the semaphore that a truncated index would alias.

// File: rtl/spinlock_pkg.sv
package spinlock_pkg;

  localparam int DATA_W         = 32;
  localparam int LOCK_BASE_WORD = 'h100 / 4;  // first semaphore word
  localparam int CODE_LSB       = 28;         // count code field position

  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_STATUS = 2'd1,
    TGT_LOCK   = 2'd2
  } target_e;

  function automatic bit count_ok(input int n);
    return (n == 32) || (n == 64) || (n == 128) || (n == 256);
  endfunction

  function automatic logic [DATA_W-1:0] status_word(input int n);
    logic [3:0] code;
    code = 4'($clog2(n) - 4);
    return {code, {CODE_LSB{1'b0}}};
  endfunction

endpackage

// File: rtl/spinlock_decoder.sv
module spinlock_decoder
  import spinlock_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_LOCKS = 32,
  parameter int IDX_W     = $clog2(NUM_LOCKS)
) (
  input  logic [ADDR_W-1:0] addr,
  output target_e           tgt,
  output logic [IDX_W-1:0]  idx
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] rel;
  logic              aligned;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign rel     = word - WORD_W'(LOCK_BASE_WORD);
  assign idx     = rel[IDX_W-1:0];

  always_comb begin
    tgt = TGT_NONE;
    if (aligned) begin
      if (word == '0)
        tgt = TGT_STATUS;
      else if (word >= WORD_W'(LOCK_BASE_WORD) && rel < WORD_W'(NUM_LOCKS))
        tgt = TGT_LOCK;
    end
  end
endmodule

// File: rtl/spinlock_core.sv
module spinlock_core #(
  parameter int NUM_PORTS = 2,
  parameter int NUM_LOCKS = 32,
  parameter int IDX_W     = $clog2(NUM_LOCKS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_PORTS-1:0]             acq_req,
  input  logic [NUM_PORTS-1:0]             rel_req,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0]  idx,
  output logic [NUM_PORTS-1:0]             was_held
);
  logic [NUM_LOCKS-1:0] held_q;
  logic [NUM_LOCKS-1:0] held_d;

  // Ports apply in ascending order; port 0 sees the oldest state.
  always_comb begin
    held_d   = held_q;
    was_held = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (acq_req[p]) begin
        was_held[p]    = held_d[idx[p]];
        held_d[idx[p]] = 1'b1;
      end else if (rel_req[p]) begin
        held_d[idx[p]] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end
endmodule

// File: rtl/spinlock_resp.sv
module spinlock_resp #(
  parameter int NUM_PORTS = 2,
  parameter int DATA_W    = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_PORTS-1:0]             access,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] data,
  output logic [NUM_PORTS-1:0]             rsp_ready,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_ready <= '0;
      rsp_rdata <= '0;
    end else begin
      rsp_ready <= access;
      rsp_rdata <= data;
    end
  end
endmodule

// File: rtl/hw_spinlock_bank.sv
module hw_spinlock_bank
  import spinlock_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int NUM_LOCKS = 32,
  parameter int ADDR_W    = 12
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_PORTS-1:0]             req_rd,
  input  logic [NUM_PORTS-1:0]             req_wr,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] req_addr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] req_wdata,
  output logic [NUM_PORTS-1:0]             rsp_ready,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] rsp_rdata
);
  localparam int                IDX_W   = $clog2(NUM_LOCKS);
  localparam logic [DATA_W-1:0] ID_WORD = status_word(NUM_LOCKS);

  // Elaboration guards on the parameters
  if (!count_ok(NUM_LOCKS)) begin : g_bad_count
    $error("hw_spinlock_bank: NUM_LOCKS must be 32, 64, 128 or 256");
  end
  if ((1 << (ADDR_W - 2)) < LOCK_BASE_WORD + NUM_LOCKS) begin : g_bad_addr
    $error("hw_spinlock_bank: ADDR_W too small for the semaphore window");
  end

  target_e [NUM_PORTS-1:0]             tgt;
  logic    [NUM_PORTS-1:0][IDX_W-1:0]  idx;
  logic    [NUM_PORTS-1:0]             acq_req;
  logic    [NUM_PORTS-1:0]             rel_req;
  logic    [NUM_PORTS-1:0]             was_held;
  logic    [NUM_PORTS-1:0]             access;
  logic    [NUM_PORTS-1:0][DATA_W-1:0] rd_data;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    spinlock_decoder #(
      .ADDR_W   (ADDR_W),
      .NUM_LOCKS(NUM_LOCKS),
      .IDX_W    (IDX_W)
    ) u_dec (
      .addr(req_addr[p]),
      .tgt (tgt[p]),
      .idx (idx[p])
    );

    // A read wins over a simultaneous write on the same port.
    assign acq_req[p] = req_rd[p] && (tgt[p] == TGT_LOCK);
    assign rel_req[p] = !req_rd[p] && req_wr[p] && (tgt[p] == TGT_LOCK)
                        && (req_wdata[p] == '0);
    assign access[p]  = req_rd[p] || req_wr[p];

    always_comb begin
      rd_data[p] = '0;
      if (req_rd[p]) begin
        case (tgt[p])
          TGT_STATUS: rd_data[p] = ID_WORD;
          TGT_LOCK:   rd_data[p] = DATA_W'(was_held[p]);
          default:    rd_data[p] = '0;
        endcase
      end
    end
  end

  spinlock_core #(
    .NUM_PORTS(NUM_PORTS),
    .NUM_LOCKS(NUM_LOCKS),
    .IDX_W    (IDX_W)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .acq_req (acq_req),
    .rel_req (rel_req),
    .idx     (idx),
    .was_held(was_held)
  );

  spinlock_resp #(
    .NUM_PORTS(NUM_PORTS),
    .DATA_W   (DATA_W)
  ) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .access   (access),
    .data     (rd_data),
    .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/spinlock_bank_chk.sv
module spinlock_bank_chk #(
  parameter int NUM_PORTS = 2,
  parameter int NUM_LOCKS = 32,
  parameter int ADDR_W    = 12
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_PORTS-1:0]             req_rd,
  input logic [NUM_PORTS-1:0]             req_wr,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0] req_addr,
  input logic [NUM_PORTS-1:0]             rsp_ready,
  input logic [NUM_PORTS-1:0][31:0]       rsp_rdata
);
  localparam logic [31:0]       EXP_ID = 32'($clog2(NUM_LOCKS) - 4) << 28;
  localparam logic [ADDR_W-1:0] LO     = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] HI     = ADDR_W'('h100 + 4 * NUM_LOCKS);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> rsp_ready == '0);

  assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rsp_ready == $past(req_rd | req_wr));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    assert_id_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(req_rd[p]) && $past(req_addr[p]) == '0
      |-> rsp_rdata[p] == EXP_ID);

    assert_lock_bit_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(req_rd[p]) && $past(req_addr[p]) >= LO
      && $past(req_addr[p]) < HI
      |-> rsp_rdata[p][31:1] == '0);

    assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(req_rd[p]) && $past(req_addr[p]) != '0
      && ($past(req_addr[p]) < LO || $past(req_addr[p]) >= HI
          || $past(req_addr[p][1:0]) != 2'b00)
      |-> rsp_rdata[p] == '0);

    assert_write_data_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(req_rd[p]) |-> rsp_rdata[p] == '0);

    if (p > 0) begin : g_pri
      assert_lower_port_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_rd[0]) && $past(req_rd[p])
        && $past(req_addr[p]) == $past(req_addr[0])
        && $past(req_addr[p]) >= LO && $past(req_addr[p]) < HI
        && $past(req_addr[p][1:0]) == 2'b00
        |-> rsp_rdata[p] == 32'd1);
    end
  end
endmodule

bind hw_spinlock_bank spinlock_bank_chk #(
  .NUM_PORTS(NUM_PORTS),
  .NUM_LOCKS(NUM_LOCKS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_rd   (req_rd),
  .req_wr   (req_wr),
  .req_addr (req_addr),
  .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata)
);

// File: tb/test_hw_spinlock_bank.sv
`timescale 1ns/1ps
module test_hw_spinlock_bank;
  localparam int NP = 2;
  localparam int AW = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]         req_rd = '0;
  logic [NP-1:0]         req_wr = '0;
  logic [NP-1:0][AW-1:0] req_addr = '0;
  logic [NP-1:0][31:0]   req_wdata = '0;
  logic [NP-1:0]         rsp_ready;
  logic [NP-1:0][31:0]   rsp_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  hw_spinlock_bank #(.NUM_PORTS(NP), .NUM_LOCKS(32), .ADDR_W(AW)) i_hw_spinlock_bank (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 12'h000, 32'h0,        32'h1000_0000, 8'd2},  // R2 id word
    '{1'b0, 1'b1, 12'h000, 32'hFFFF_FFFF, 32'h0,        8'd6},  // R6 write id
    '{1'b1, 1'b0, 12'h000, 32'h0,        32'h1000_0000, 8'd6},  // R6 unchanged
    '{1'b1, 1'b0, 12'h100, 32'h0,        32'h0,         8'd3},  // R3 take lock 0
    '{1'b1, 1'b0, 12'h100, 32'h0,        32'h1,         8'd4},  // R4 held
    '{1'b1, 1'b0, 12'h100, 32'h0,        32'h1,         8'd4},  // R4 still held
    '{1'b0, 1'b1, 12'h100, 32'h5,        32'h0,         8'd6},  // R6 nonzero write
    '{1'b1, 1'b0, 12'h100, 32'h0,        32'h1,         8'd6},  // R6 still held
    '{1'b0, 1'b1, 12'h100, 32'h0,        32'h0,         8'd5},  // R5 release
    '{1'b1, 1'b0, 12'h100, 32'h0,        32'h0,         8'd5},  // R5 free again
    '{1'b1, 1'b0, 12'h17C, 32'h0,        32'h0,         8'd3},  // R3 last lock
    '{1'b1, 1'b0, 12'h17C, 32'h0,        32'h1,         8'd4},  // R4
    '{1'b1, 1'b0, 12'h180, 32'h0,        32'h0,         8'd7},  // R7 index 32
    '{1'b1, 1'b0, 12'h180, 32'h0,        32'h0,         8'd7},  // R7 no side effect
    '{1'b1, 1'b0, 12'h004, 32'h0,        32'h0,         8'd7},  // R7 gap
    '{1'b1, 1'b0, 12'h0FC, 32'h0,        32'h0,         8'd7},  // R7 gap
    '{1'b0, 1'b1, 12'h17C, 32'h0,        32'h0,         8'd5},  // R5 release last
    '{1'b1, 1'b0, 12'h17C, 32'h0,        32'h0,         8'd5},  // R5
    '{1'b1, 1'b0, 12'h10A, 32'h0,        32'h0,         8'd7},  // R7 unaligned
    '{1'b1, 1'b0, 12'h208, 32'h0,        32'h0,         8'd7},  // R7 index 66
    '{1'b1, 1'b0, 12'h108, 32'h0,        32'h0,         8'd3}   // R3 lock 2 not aliased
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // One access cycle; returns at the negedge where responses are visible.
  task automatic access(input logic [1:0] rd, input logic [1:0] wr,
                        input logic [11:0] a0, input logic [11:0] a1,
                        input logic [31:0] d0, input logic [31:0] d1);
    @(negedge clk);
    req_rd = rd; req_wr = wr;
    req_addr[0] = a0; req_addr[1] = a1;
    req_wdata[0] = d0; req_wdata[1] = d1;
    @(negedge clk);
    req_rd = '0; req_wr = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready in reset", 32'(rsp_ready), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 32'(rsp_ready), 32'h0);
    access(2'b01, 2'b00, 12'h114, 12'h0, 32'h0, 32'h0);
    check("R1 lock 5 free", rsp_rdata[0], 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      access({1'b0, VECS[i].rd}, {1'b0, VECS[i].wr}, VECS[i].addr, 12'h0,
             VECS[i].wdata, 32'h0);
      check($sformatf("R8 ready vec %0d", i), 32'(rsp_ready), 32'h1);
      check($sformatf("R%0d data vec %0d", VECS[i].req, i), rsp_rdata[0], VECS[i].exp);
    end

    // R8: pulse lasts one cycle
    @(negedge clk);
    check("R8 ready drops", 32'(rsp_ready), 32'h0);

    // R2 on port 1
    access(2'b10, 2'b00, 12'h0, 12'h000, 32'h0, 32'h0);
    check("R2 port1 id", rsp_rdata[1], 32'h1000_0000);

    // R9 collision on free lock 3
    access(2'b11, 2'b00, 12'h10C, 12'h10C, 32'h0, 32'h0);
    check("R9 port0 wins", rsp_rdata[0], 32'h0);
    check("R9 port1 loses", rsp_rdata[1], 32'h1);
    access(2'b11, 2'b00, 12'h10C, 12'h10C, 32'h0, 32'h0);
    check("R9 both see held p0", rsp_rdata[0], 32'h1);
    check("R9 both see held p1", rsp_rdata[1], 32'h1);

    // R10 release on port 0 then read on port 1, same cycle
    access(2'b10, 2'b01, 12'h10C, 12'h10C, 32'h0, 32'h0);
    check("R10 p1 gets released lock", rsp_rdata[1], 32'h0);
    check("R10 both ready", 32'(rsp_ready), 32'h3);
    access(2'b01, 2'b00, 12'h10C, 12'h0, 32'h0, 32'h0);
    check("R10 lock 3 held by p1", rsp_rdata[0], 32'h1);

    // R10 read and write together on port 1: read only
    access(2'b10, 2'b10, 12'h0, 12'h110, 32'h0, 32'h0);
    check("R10 rd+wr acts as read", rsp_rdata[1], 32'h0);
    access(2'b01, 2'b00, 12'h110, 12'h0, 32'h0, 32'h0);
    check("R10 lock 4 now held", rsp_rdata[0], 32'h1);

    // R1 reset mid-run frees lock 0
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after re-reset", 32'(rsp_ready), 32'h0);
    access(2'b01, 2'b00, 12'h100, 12'h0, 32'h0, 32'h0);
    check("R1 lock 0 freed by reset", rsp_rdata[0], 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule